// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block drives a character LCD module of the common parallel type through an 8-bit data bus, an enable strobe, a register-select line and a read/write line. It runs from a single fast system clock. A free-running divider produces a one-cycle step enable at roughly 400 Hz, and the sequencer moves forward by at most one step on each such pulse. Between pulses, every output holds its value.

After reset the sequencer sends the power-up command train that puts the display controller into 8-bit, two-line mode. It turns the display on with the cursor hidden, clears the screen and selects auto-increment. It then writes characters to the first line and jumps to the second line. After the second line it returns the cursor home and refreshes both lines without end.

All bytes go through one shared strobe pair: a step with the enable high and the bus settled, then a step with the enable low. A return-state register then selects which step comes next. A separate display-power output follows a switch input.

Top module: `charlcd_seq`

## Requirements
- R1: While reset is low, and with no clock edge needed, the outputs are: enable high, register-select low, read/write low, data 0x38, power output low.
- R2: The step enable is a single-cycle pulse that comes once every TICK_LIMIT+2 clocks. Enable, register-select and data change only in the clock after a pulse, so successive enable edges are exactly TICK_LIMIT+2 clocks apart.
- R3: The read/write output is low at all times (write only).
- R4: The power output is registered and equals the switch input as it was one clock earlier, whatever the sequencer is doing in that cycle.
- R5: Each byte is strobed with the enable high for one step and then low for one step. Data and register-select do not change at the falling edge, so the display takes the byte on the falling edge of the enable.
- R6: The first bytes taken after reset, all with register-select low, are 0x38 four times, then 0x0C, then 0x01, then 0x06.
- R7: Next come LINE_LEN character bytes with register-select high. The value of character i is 0x41 + (i mod 26).
- R8: After the first line comes command 0xC0 with register-select low. Then come LINE_LEN character bytes with register-select high, where character i is 0x30 + (i mod 10).
- R9: After the second line comes command 0x80 with register-select low. The sequencer then starts the first line again, without repeating the initialisation.
- R10: Pulling reset low in the middle of a run restores the R1 outputs at once. After release, the byte stream restarts from the R6 initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Reset, active low; asserts asynchronously, released synchronously |
| pwr_sw | input | 1 | Display power switch |
| lcd_pwr | output | 1 | Display power enable |
| lcd_data | output | 8 | Parallel data bus to the display |
| lcd_e | output | 1 | Enable strobe; the byte is taken on its falling edge |
| lcd_rs | output | 1 | Register select: 0 for command, 1 for character |
| lcd_rw | output | 1 | Read/write, held at write (0) |

## Verification
A change of the power switch can land in the same clock as a step enable that drops the strobe. The bench provokes this by flipping the switch in the very cycle it sees a byte taken. It then judges that the power output follows one clock later and that the byte stream captured afterwards still matches the expected order. A second collision, reset in the middle of a strobe, is provoked directly. It is judged by the immediate return to the reset outputs and by a fresh initialisation stream.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

  typedef enum logic [3:0] {
    ST_RST1, ST_RST2, ST_RST3, ST_FUNC, ST_DISP, ST_CLR, ST_ENTRY,
    ST_LINE1, ST_JUMP2, ST_LINE2, ST_HOME, ST_DROP
  } step_t;

  localparam logic [7:0] CMD_FUNC  = 8'h38;
  localparam logic [7:0] CMD_DISP  = 8'h0C;
  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_ENTRY = 8'h06;
  localparam logic [7:0] CMD_ROW2  = 8'hC0;
  localparam logic [7:0] CMD_ROW1  = 8'h80;

  // character for position idx on row 1 (second=0) or row 2 (second=1)
  function automatic logic [7:0] glyph_of(input logic second, input int unsigned idx);
    logic [7:0] g;
    if (second) g = 8'h30 + 8'(idx % 10);
    else        g = 8'h41 + 8'(idx % 26);
    return g;
  endfunction

endpackage

// File: rtl/charlcd_rstsync.sv
module charlcd_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      meta  <= 1'b1;
      rst_s <= meta;
    end
  end
endmodule

// File: rtl/charlcd_tick.sv
module charlcd_tick #(
  parameter int unsigned LIMIT = 62500,
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_d;

  always_comb begin
    if (cnt_q <= LIM) begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end else begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/charlcd_glyph.sv
module charlcd_glyph #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             row2,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       code
);
  import charlcd_pkg::*;

  always_comb code = glyph_of(row2, int'(idx));
endmodule

// File: rtl/charlcd_fsm.sv
module charlcd_fsm #(
  parameter int unsigned LINE_LEN = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [7:0]       glyph,
  output logic             row2,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       data,
  output logic             e,
  output logic             rs
);
  import charlcd_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_LEN - 1);

  step_t            st_q, st_d, ret_q, ret_d;
  logic [IDX_W-1:0] idx_d;
  logic [7:0]       data_d;
  logic             e_d, rs_d;

  assign row2 = (st_q == ST_LINE2);

  always_comb begin
    st_d   = st_q;
    ret_d  = ret_q;
    idx_d  = idx;
    data_d = data;
    e_d    = e;
    rs_d   = rs;
    if (step) begin
      // byte states raise the strobe and go to ST_DROP; ST_DROP follows ret_q
      case (st_q)
        ST_RST1, ST_DROP: begin
          e_d  = 1'b0;
          st_d = ret_q;
        end
        ST_RST2: begin
          data_d = CMD_FUNC; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_RST3;  st_d = ST_DROP;
        end
        ST_RST3: begin
          data_d = CMD_FUNC; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_FUNC;  st_d = ST_DROP;
        end
        ST_FUNC: begin
          data_d = CMD_FUNC; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_DISP;  st_d = ST_DROP;
        end
        ST_DISP: begin
          data_d = CMD_DISP; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_CLR;   st_d = ST_DROP;
        end
        ST_CLR: begin
          data_d = CMD_CLEAR; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_ENTRY;  st_d = ST_DROP;
        end
        ST_ENTRY: begin
          data_d = CMD_ENTRY; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_LINE1;  st_d = ST_DROP;
          idx_d  = '0;
        end
        ST_LINE1, ST_LINE2: begin
          data_d = glyph; rs_d = 1'b1; e_d = 1'b1;
          st_d   = ST_DROP;
          if (idx == LAST) begin
            idx_d = '0;
            ret_d = (st_q == ST_LINE1) ? ST_JUMP2 : ST_HOME;
          end else begin
            idx_d = idx + 1'b1;
            ret_d = st_q;
          end
        end
        ST_JUMP2: begin
          data_d = CMD_ROW2; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_LINE2; st_d = ST_DROP;
        end
        ST_HOME: begin
          data_d = CMD_ROW1; rs_d = 1'b0; e_d = 1'b1;
          ret_d  = ST_LINE1; st_d = ST_DROP;
        end
        default: begin
          st_d = ST_RST1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RST1;
      ret_q <= ST_RST2;
      idx   <= '0;
      data  <= CMD_FUNC;
      e     <= 1'b1;
      rs    <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      idx   <= idx_d;
      data  <= data_d;
      e     <= e_d;
      rs    <= rs_d;
    end
  end
endmodule

// File: rtl/charlcd_seq.sv
module charlcd_seq #(
  parameter int unsigned TICK_LIMIT = 62500,
  parameter int unsigned LINE_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_sw,
  output logic       lcd_pwr,
  output logic [7:0] lcd_data,
  output logic       lcd_e,
  output logic       lcd_rs,
  output logic       lcd_rw
);
  localparam int unsigned CNT_W = $clog2(TICK_LIMIT + 2);
  localparam int unsigned IDX_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  logic             rst_s;
  logic             tick;
  logic             row2;
  logic [IDX_W-1:0] idx;
  logic [7:0]       glyph;

  charlcd_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  charlcd_tick #(.LIMIT(TICK_LIMIT), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_s), .tick(tick)
  );

  charlcd_glyph #(.IDX_W(IDX_W)) u_glyph (.row2(row2), .idx(idx), .code(glyph));

  charlcd_fsm #(.LINE_LEN(LINE_LEN), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_s), .step(tick), .glyph(glyph),
    .row2(row2), .idx(idx), .data(lcd_data), .e(lcd_e), .rs(lcd_rs)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) lcd_pwr <= 1'b0;
    else        lcd_pwr <= pwr_sw;
  end

  assign lcd_rw = 1'b0;
endmodule

// File: rtl/charlcd_seq_chk.sv
module charlcd_seq_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       tick,
  input logic       pwr_sw,
  input logic       lcd_pwr,
  input logic [7:0] lcd_data,
  input logic       lcd_e,
  input logic       lcd_rs
);
  // R2: the step enable never lasts two cycles
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_s)
    tick |=> !tick);

  // R2: bus outputs move only in the clock after a step enable
  p_hold_between_steps_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable({lcd_e, lcd_rs, lcd_data}) |-> $past(tick));

  // R4: power output is the switch one clock late
  p_pwr_follow_r4: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> lcd_pwr == $past(pwr_sw));

  // R5: data and register select are settled at the falling strobe
  p_bus_stable_fall_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(lcd_e) |-> ($stable(lcd_data) && $stable(lcd_rs)));

  // R5: a strobe stays high for more than one clock
  p_e_width_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(lcd_e) |=> lcd_e);
endmodule

bind charlcd_seq charlcd_seq_chk u_chk (
  .clk(clk), .rst_s(rst_s), .tick(tick), .pwr_sw(pwr_sw), .lcd_pwr(lcd_pwr),
  .lcd_data(lcd_data), .lcd_e(lcd_e), .lcd_rs(lcd_rs)
);

// File: tb/sim_charlcd_seq.sv
`timescale 1ns/1ps
module sim_charlcd_seq;
  localparam int unsigned LIM = 2;
  localparam int unsigned LEN = 4;
  localparam int unsigned PERIOD = LIM + 2;
  localparam int NEXP = 22;
  // {rs, data} expected at each falling edge of the strobe (LEN = 4)
  localparam logic [8:0] EXP [NEXP] = '{
    9'h038, 9'h038, 9'h038, 9'h038, 9'h00C, 9'h001, 9'h006,
    9'h141, 9'h142, 9'h143, 9'h144, 9'h0C0,
    9'h130, 9'h131, 9'h132, 9'h133, 9'h080,
    9'h141, 9'h142, 9'h143, 9'h144, 9'h0C0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_sw;
  logic lcd_pwr, lcd_e, lcd_rs, lcd_rw;
  logic [7:0] lcd_data;

  int checks = 0;
  int fails  = 0;
  logic [8:0] cap [64];
  int ncap = 0;
  int cyc = 0;
  int last_edge = -1;
  int nint = 0;
  logic e_prev = 1'b1;
  bit done = 0;

  always #2.5 clk = ~clk;

  charlcd_seq #(.TICK_LIMIT(LIM), .LINE_LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_sw(pwr_sw), .lcd_pwr(lcd_pwr),
    .lcd_data(lcd_data), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // capture bytes on falling strobe, measure edge spacing (R2), watch rw (R3)
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_edge = -1;
      e_prev = lcd_e;
    end else begin
      if (lcd_rw !== 1'b0) check("R3 rw", 32'(lcd_rw), 0);
      if (lcd_e !== e_prev) begin
        if (last_edge >= 0 && nint < 12) begin
          nint++;
          check("R2 edge spacing", 32'(cyc - last_edge), 32'(PERIOD));
        end
        last_edge = cyc;
        if (e_prev && !lcd_e && ncap < 64) begin
          cap[ncap] = {lcd_rs, lcd_data};
          ncap++;
        end
        e_prev = lcd_e;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int base;
    rst_n = 1'b0;
    pwr_sw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check("R1 e", 32'(lcd_e), 1);
    check("R1 rs", 32'(lcd_rs), 0);
    check("R1 data", 32'(lcd_data), 32'h38);
    check("R1 pwr", 32'(lcd_pwr), 0);
    check("R3 rw", 32'(lcd_rw), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pwr_sw = 1'b1;
    @(negedge clk);
    check("R4 pwr on", 32'(lcd_pwr), 1);
    // switch flips in the same cycle a byte is taken
    wait (ncap == 5);
    pwr_sw = 1'b0;
    @(negedge clk);
    check("R4 pwr off at strobe", 32'(lcd_pwr), 0);
    wait (ncap >= NEXP);
    // R6 init, R7 row 1, R8 row 2, R9 home and loop
    for (int i = 0; i < NEXP; i++) begin
      string tag;
      if (i < 7) tag = "R6 init byte";
      else if (i < 11) tag = "R7 row1 char";
      else if (i < 16) tag = "R8 row2";
      else tag = "R9 home/loop";
      check(tag, 32'(cap[i]), 32'(EXP[i]));
    end
    // R10 reset mid-strobe
    pwr_sw = 1'b1;
    wait (lcd_e == 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 e", 32'(lcd_e), 1);
    check("R10 rs", 32'(lcd_rs), 0);
    check("R10 data", 32'(lcd_data), 32'h38);
    check("R1 pwr in reset", 32'(lcd_pwr), 0);
    repeat (2) @(negedge clk);
    base = ncap;
    rst_n = 1'b1;
    wait (ncap >= base + 7);
    for (int i = 0; i < 7; i++)
      check("R10 restart init", 32'(cap[base + i]), 32'(EXP[i]));
    done = 1;
    finish_run();
  end
endmodule